// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Latch

The block collects a serial bit stream in an 8-stage shift rank and copies that rank on demand into a separate storage rank that drives eight parallel outputs. Two strobe inputs are used, one to shift and one to latch. Both strobes, the serial data and the clear input are brought into the system clock domain through two-flop synchronizers. A rising edge on either strobe becomes a single-cycle event. The last shift stage leaves the block as a serial cascade output, so several blocks can be chained into a longer register that shares the same strobes.

The clear input is active low. It empties only the shift rank, and the parallel outputs keep whatever was last latched. The output-drive input is also active low. When it is high, all parallel pins are released to high impedance. This is modelled as a per-bit drive enable alongside the data bus. If both strobes rise in the same cycle, the shift takes place and the storage rank takes the contents from before that shift.

Top module: `srl_latch_top`

## Requirements
- R1: A shift-strobe rising edge moves the synchronized serial input into stage 0, and stage n+1 takes the old value of stage n.
- R2: `ser_out` always equals shift stage 7. After a shift it therefore shows the old value of stage 6. `drive_n` has no effect on it.
- R3: A latch-strobe rising edge copies all stages into the storage rank, and `par_q[n]` equals stored bit n.
- R4: While `clear_n` is low, every shift stage is zero and the storage rank and `par_q` keep their values.
- R5: A latch-strobe edge while `clear_n` is low loads all zeros into the storage rank.
- R6: `par_en[n]`=1 means pin n is driven. With `drive_n` low, all bits of `par_en` are 1. With `drive_n` high, all bits are 0 (high impedance), and the data on `par_q` is still held.
- R7: When both strobes rise in the same cycle, the shift happens and the storage rank captures the pre-shift stages.
- R8: A strobe held high acts once. Only its rising edge counts.
- R9: Clear takes priority over a shift edge in the same cycle, so the stages stay zero.
- R10: Two blocks chained through `ser_out` to `ser_in` with shared strobes behave as one 16-bit register. After 16 shifts and one latch, the first block holds the last 8 bits shifted in and the second block holds the first 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ser_in | input | 1 | Serial data input |
| shift_stb | input | 1 | Shift strobe; its rising edge shifts |
| latch_stb | input | 1 | Latch strobe; its rising edge copies to storage |
| clear_n | input | 1 | Active-low clear of the shift rank only |
| drive_n | input | 1 | Active-low parallel output drive |
| par_q | output | 8 | Parallel data from the storage rank |
| par_en | output | 8 | Per-bit drive enable; 0 means high impedance |
| ser_out | output | 1 | Serial cascade output, shift stage 7 |

## Verification
The hardest cases to reach are the coincident events, because all of them happen inside the synchronizers. These are a latch edge and a shift edge that land in the same system cycle, and a latch edge that lands while clear is held. The bench raises the strobes together from one task, so both pass through equal-depth synchronizers and fire on the same cycle. It also issues strobes while clear is held low. A sweep of all 256 byte values shifts each one through a chained pair of blocks and checks both serial outputs after every shift. During the sweep it periodically releases the output drive.

// File: rtl/srl_pkg.sv
package srl_pkg;
  // Lane positions inside the shared input synchronizer.
  localparam int LANE_DIN   = 0;
  localparam int LANE_CLR   = 1;
  localparam int LANE_SHIFT = 2;
  localparam int LANE_LATCH = 3;
  localparam int LANES      = 4;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] pipe;

  always_ff @(posedge clk) begin
    pipe[0] <= d;
    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srl_rise.sv
module srl_rise #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  function automatic logic [N-1:0] rise_of(input logic [N-1:0] cur, input logic [N-1:0] old);
    return cur & ~old;
  endfunction

  always_ff @(posedge clk) prev <= lvl;

  assign rise = rise_of(lvl, prev);
endmodule

// File: rtl/srl_shift_rank.sv
module srl_shift_rank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_act,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] stage
);
  function automatic logic [W-1:0] next_stage(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (clr_act)   stage <= '0;
    else if (step) stage <= next_stage(stage, din);
  end
endmodule

// File: rtl/srl_store_rank.sv
module srl_store_rank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         grab,
  input  logic         clr_act,
  input  logic [W-1:0] src,
  output logic [W-1:0] held
);
  function automatic logic [W-1:0] capture_value(input logic [W-1:0] s, input logic clr);
    return clr ? '0 : s;
  endfunction

  always_ff @(posedge clk) begin
    if (grab) held <= capture_value(src, clr_act);
  end
endmodule

// File: rtl/srl_latch_top.sv
module srl_latch_top #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             clear_n,
  input  logic             drive_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_en,
  output logic             ser_out
);
  import srl_pkg::*;

  logic [LANES-1:0] raw_lanes;
  logic [LANES-1:0] sync_lanes;
  logic [1:0]       edges;
  logic             din_s;
  logic             clr_act;
  logic             shift_evt;
  logic             latch_evt;
  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] held;

  assign raw_lanes[LANE_DIN]   = ser_in;
  assign raw_lanes[LANE_CLR]   = clear_n;
  assign raw_lanes[LANE_SHIFT] = shift_stb;
  assign raw_lanes[LANE_LATCH] = latch_stb;

  srl_sync #(.N(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_lanes),
    .q   (sync_lanes)
  );

  srl_rise #(.N(2)) u_rise (
    .clk  (clk),
    .lvl  (sync_lanes[LANE_LATCH:LANE_SHIFT]),
    .rise (edges)
  );

  assign din_s     = sync_lanes[LANE_DIN];
  assign clr_act   = ~sync_lanes[LANE_CLR];
  assign shift_evt = edges[0];
  assign latch_evt = edges[1];

  srl_shift_rank #(.W(WIDTH)) u_shift (
    .clk     (clk),
    .clr_act (clr_act),
    .step    (shift_evt),
    .din     (din_s),
    .stage   (stage)
  );

  srl_store_rank #(.W(WIDTH)) u_store (
    .clk     (clk),
    .grab    (latch_evt),
    .clr_act (clr_act),
    .src     (stage),
    .held    (held)
  );

  assign par_q   = held;
  assign par_en  = {WIDTH{~drive_n}};
  assign ser_out = stage[WIDTH-1];
endmodule

// File: rtl/srl_latch_chk.sv
module srl_latch_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         din_s,
  input logic         clr_act,
  input logic         shift_evt,
  input logic         latch_evt,
  input logic [W-1:0] stage,
  input logic [W-1:0] par_q,
  input logic [W-1:0] par_en,
  input logic         ser_out
);
  logic [2:0] warm = 3'd0;
  logic       seen_latch = 1'b0;
  logic       ready;

  always_ff @(posedge clk) begin
    if (warm != 3'd7) warm <= warm + 3'd1;
    if (latch_evt && warm == 3'd7) seen_latch <= 1'b1;
  end
  assign ready = (warm == 3'd7) && seen_latch;

  p_shift_step_r1: assert property (@(posedge clk) disable iff (!ready)
    shift_evt && !clr_act |=> stage == {$past(stage[W-2:0]), $past(din_s)});

  p_ser_tap_r2: assert property (@(posedge clk) disable iff (!ready)
    shift_evt && !clr_act |=> ser_out == $past(stage[W-2]));

  p_ser_idle_r2: assert property (@(posedge clk) disable iff (!ready)
    !shift_evt && !clr_act |=> $stable(ser_out));

  p_latch_copy_r3: assert property (@(posedge clk) disable iff (!ready)
    latch_evt && !clr_act |=> par_q == $past(stage));

  p_clear_hold_r4: assert property (@(posedge clk) disable iff (!ready)
    clr_act && !latch_evt |=> stage == '0 && par_q == $past(par_q));

  p_latch_zero_r5: assert property (@(posedge clk) disable iff (!ready)
    latch_evt && clr_act |=> par_q == '0);

  p_en_uniform_r6: assert property (@(posedge clk) disable iff (!ready)
    par_en == '0 || (&par_en));

  p_both_order_r7: assert property (@(posedge clk) disable iff (!ready)
    shift_evt && latch_evt && !clr_act |=> par_q == $past(stage));

  p_shift_pulse_r8: assert property (@(posedge clk) disable iff (!ready)
    shift_evt |=> !shift_evt);

  p_latch_pulse_r8: assert property (@(posedge clk) disable iff (!ready)
    latch_evt |=> !latch_evt);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!ready)
    clr_act && shift_evt |=> stage == '0);
endmodule

bind srl_latch_top srl_latch_chk #(.W(WIDTH)) u_chk (
  .clk       (clk),
  .din_s     (din_s),
  .clr_act   (clr_act),
  .shift_evt (shift_evt),
  .latch_evt (latch_evt),
  .stage     (stage),
  .par_q     (par_q),
  .par_en    (par_en),
  .ser_out   (ser_out)
);

// File: tb/tb_srl_latch_top.sv
`timescale 1ns/1ps
module tb_srl_latch_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic ser_in = 1'b0, shift_stb = 1'b0, latch_stb = 1'b0, clear_n = 1'b0, drive_n = 1'b1;
  logic [7:0] pa, pb, ea, eb;
  logic sa, sb;

  srl_latch_top dut (
    .clk(clk), .ser_in(ser_in), .shift_stb(shift_stb), .latch_stb(latch_stb),
    .clear_n(clear_n), .drive_n(drive_n), .par_q(pa), .par_en(ea), .ser_out(sa));

  srl_latch_top dut2 (
    .clk(clk), .ser_in(sa), .shift_stb(shift_stb), .latch_stb(latch_stb),
    .clear_n(clear_n), .drive_n(drive_n), .par_q(pb), .par_en(eb), .ser_out(sb));

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [15:0] chain = 16'h0;
  logic [7:0] ma = 8'h0, mb = 8'h0;
  bit clr_model = 1'b1;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit sh, input bit st, input bit d);
    ser_in = d;
    idle(2);
    shift_stb = sh;
    latch_stb = st;
    idle(6);
    if (st) begin
      ma = clr_model ? 8'h00 : chain[7:0];
      mb = clr_model ? 8'h00 : chain[15:8];
    end
    if (clr_model) chain = 16'h0;
    else if (sh) chain = {chain[14:0], d};
    shift_stb = 1'b0;
    latch_stb = 1'b0;
    idle(3);
  endtask

  task automatic set_clear(input bit v);
    clear_n = v;
    idle(5);
    clr_model = !v;
    if (!v) chain = 16'h0;
  endtask

  task automatic check_ser(input string tag);
    check(tag, {14'h0, sb, sa}, {14'h0, chain[15], chain[7]});
  endtask

  task automatic check_par(input string tag);
    check(tag, {pb, pa}, {mb, ma});
  endtask

  task automatic check_en(input string tag);
    check(tag, {eb, ea}, drive_n ? 16'h0000 : 16'hFFFF);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // Reset state: clear held, outputs released
    idle(6);
    clr_model = 1'b1;
    chain = 16'h0;
    check_ser("R4 reset ser_out zero");
    check_en("R6 released at reset");
    strobe(1'b0, 1'b1, 1'b0);
    check_par("R5 latch during clear gives zeros");
    set_clear(1'b1);
    drive_n = 1'b0;
    idle(1);
    check_en("R6 driven");

    // Exhaustive byte sweep through the chained pair
    for (int v = 0; v < 256; v++) begin
      for (int b = 7; b >= 0; b--) begin
        strobe(1'b1, 1'b0, v[b]);
        check_ser("R1 R2 R10 serial after shift");
      end
      strobe(1'b0, 1'b1, 1'b0);
      check_par("R3 R10 parallel after latch");
      if (v[7:0] == 8'hFF) check(" R1 byte in first block", {8'h0, pa}, v[15:0]);
      if ((v % 16) == 5) begin
        drive_n = 1'b1;
        idle(1);
        check_en("R6 released mid sweep");
        check_par("R6 data held while released");
        strobe(1'b1, 1'b0, 1'b1);
        check_ser("R2 serial unaffected by drive_n");
        drive_n = 1'b0;
        idle(1);
        check_en("R6 driven again");
      end
    end

    // Held strobe acts once
    set_clear(1'b0);
    set_clear(1'b1);
    ser_in = 1'b1;
    idle(2);
    shift_stb = 1'b1;
    idle(30);
    chain = {chain[14:0], 1'b1};
    shift_stb = 1'b0;
    idle(3);
    strobe(1'b0, 1'b1, 1'b0);
    check_par("R8 held shift strobe shifts once");
    latch_stb = 1'b1;
    idle(30);
    ma = chain[7:0];
    mb = chain[15:8];
    strobe(1'b1, 1'b0, 1'b0);
    latch_stb = 1'b0;
    idle(3);
    check_par("R8 held latch strobe copies once");

    // Simultaneous edges: pre-shift contents latched
    for (int k = 0; k < 8; k++) strobe(1'b1, 1'b0, k[0]);
    strobe(1'b1, 1'b1, 1'b1);
    check_par("R7 both strobes latch pre-shift");
    check_ser("R7 shift still applied");
    strobe(1'b0, 1'b1, 1'b0);
    check_par("R7 post-shift stages");

    // Clear keeps storage, shift dropped during clear
    for (int k = 0; k < 8; k++) strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    set_clear(1'b0);
    check_ser("R4 clear empties shift rank");
    check_par("R4 storage kept during clear");
    strobe(1'b1, 1'b0, 1'b1);
    check_ser("R9 shift ignored during clear");
    check_par("R9 storage untouched by shift in clear");
    set_clear(1'b1);
    strobe(1'b0, 1'b1, 1'b0);
    check_par("R9 nothing entered during clear");

    // Sixteen-bit cascade pattern
    begin
      logic [15:0] pat;
      pat = 16'hA5C3;
      for (int b = 15; b >= 0; b--) strobe(1'b1, 1'b0, pat[b]);
      strobe(1'b0, 1'b1, 1'b0);
      check("R10 cascade 16-bit pattern", {pb, pa}, pat);
    end

    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule